// File: doc/BRIEF.md
# BFloat16 Field Manipulation Unit

This unit sits inside a processing element. It works on 16-bit brain-float operands by treating the sign, exponent and fraction fields as plain integers rather than as an arithmetic number. Each cycle it takes two 16-bit data words and a 3-bit opcode, and it returns a 16-bit result and a 1-bit predicate.

The operations are:
- pull out the fraction field;
- shift the exponent by a signed immediate;
- take the difference of two exponents;
- turn the unbiased exponent into a float;
- split a float into its truncated integer part and its scaled fractional part;
- turn a 16-bit unsigned integer into a float.

The exponent arithmetic wraps modulo 256. NaN and infinity get no special treatment: their raw fields go through the same integer operations as any other value.

The operand layout is the sign in bit 15, the exponent in bits 14:7 with a bias of 127, and the fraction in bits 6:0. The field logic is combinational. The result and the predicate are captured in one output register stage.

Top module: `bf16_field_unit`

## Requirements
- R1: The result and predicate appear on the clock edge after the operands are presented, and they hold until the next edge. A synchronous active-high reset clears both to 0.
- R2: Opcode 0 returns bits 6:0 of operand A zero-extended to 16 bits.
- R3: Opcode 1 adds operand B bits 7:0, taken as signed, to the exponent of A modulo 256. The sign and fraction of A are kept (0x7F8A with 5 gives 0x020A).
- R4: Opcode 2 gives exponent (eA − eB + 127) mod 256, the fraction of A, and the sign (sA OR sB) (0x7F8A with 0x4005 gives 0x7F0A).
- R5: Opcode 3 returns the brain-float encoding of the integer (eA − 127), with 0 encoded as 0x0000.
- R6: Opcode 4 returns the integer part of A, truncated toward zero, as a two's-complement 16-bit value. Magnitudes of 255 and above saturate to ±255.
- R7: With opcode 4 the predicate is 1 when the magnitude of A is 255 or more, and 0 otherwise.
- R8: Opcode 5 returns the fractional part of A times 128, truncated and carrying the sign of A, as a two's-complement 16-bit value.
- R9: Opcode 6 converts A, read as an unsigned integer, to brain-float. It rounds to nearest with ties to even, a zero input gives 0x0000, and the sign bit is always 0.
- R10: For every opcode other than 4 the predicate is 0. Opcode 7 returns a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation select (0 to 7) |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B (immediate or second float) |
| res_o | output | 16 | Registered result |
| pred_o | output | 1 | Registered predicate |

## Verification
The integer-part result and the overflow predicate are produced together in the same cycle by the split operation. The bench provokes this by presenting values just under 255, exactly 255.x, and far above the limit. It judges both outputs at one sample point: the saturated result must appear with the predicate set, and 254 must appear with the predicate clear. It also follows an integer split with another opcode, to confirm the predicate drops on the very next result.

// File: rtl/bffu_pkg.sv
package bffu_pkg;
    localparam int DATA_W    = 16;
    localparam int EXP_W     = 8;
    localparam int FRAC_W    = 7;
    localparam int BIAS      = 127;
    localparam int OP_W      = 3;
    localparam int INT_LIMIT = 255;
    localparam int POS_W     = $clog2(DATA_W) + 1;
    localparam int MANT_W    = FRAC_W + 1;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } bf16_t;

    typedef enum logic [OP_W-1:0] {
        OP_MANT   = 3'd0,
        OP_ADDEXP = 3'd1,
        OP_SUBEXP = 3'd2,
        OP_EXP2F  = 3'd3,
        OP_INT    = 3'd4,
        OP_FRAC   = 3'd5,
        OP_U2F    = 3'd6,
        OP_RSVD   = 3'd7
    } bffu_op_e;

    // Index of the highest set bit; 0 for a zero word.
    function automatic logic [POS_W-1:0] top_bit(input logic [DATA_W-1:0] v);
        logic [POS_W-1:0] pos;
        pos = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (v[i]) pos = POS_W'(i);
        end
        return pos;
    endfunction

    // Align the leading one to the MSB of the word.
    function automatic logic [DATA_W-1:0] align_top(input logic [DATA_W-1:0] v,
                                                    input logic [POS_W-1:0] pos);
        return v << (POS_W'(DATA_W - 1) - pos);
    endfunction
endpackage

// File: rtl/bffu_exp_ops.sv
module bffu_exp_ops
    import bffu_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] mant_o,
    output logic [DATA_W-1:0] addexp_o,
    output logic [DATA_W-1:0] subexp_o,
    output logic [DATA_W-1:0] exp2f_o
);
    localparam logic [EXP_W-1:0] BIAS_E = EXP_W'(BIAS);

    bf16_t             x, y;
    logic [EXP_W-1:0]  sum_e, diff_e, mag, cv_exp;
    logic              neg;
    logic [POS_W-1:0]  pos;
    logic [DATA_W-1:0] norm;

    always_comb begin
        x = bf16_t'(a_i);
        y = bf16_t'(b_i);

        mant_o   = {{(DATA_W-FRAC_W){1'b0}}, x.frac};

        sum_e    = x.exp + b_i[EXP_W-1:0];
        addexp_o = {x.sign, sum_e, x.frac};

        diff_e   = x.exp - y.exp + BIAS_E;
        subexp_o = {x.sign | y.sign, diff_e, x.frac};

        neg    = x.exp < BIAS_E;
        mag    = neg ? (BIAS_E - x.exp) : (x.exp - BIAS_E);
        pos    = top_bit(DATA_W'(mag));
        norm   = align_top(DATA_W'(mag), pos);
        cv_exp = BIAS_E + EXP_W'(pos);
        if (mag == '0) begin
            exp2f_o = '0;
        end else begin
            exp2f_o = {neg, cv_exp, norm[DATA_W-2 -: FRAC_W]};
        end
    end
endmodule

// File: rtl/bffu_int_split.sv
module bffu_int_split
    import bffu_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    output logic [DATA_W-1:0] int_o,
    output logic [DATA_W-1:0] frac_o,
    output logic              ovf_o
);
    localparam logic [EXP_W-1:0] BIAS_E = EXP_W'(BIAS);
    localparam int SH_W = $clog2(MANT_W);

    bf16_t             x;
    logic [MANT_W-1:0] mant, int_mag, frac_mag, mask;
    logic [EXP_W-1:0]  up, down;
    logic [SH_W-1:0]   rs;

    always_comb begin
        x        = bf16_t'(a_i);
        mant     = {1'b1, x.frac};
        int_mag  = '0;
        frac_mag = '0;
        ovf_o    = 1'b0;
        up       = x.exp - BIAS_E;
        down     = BIAS_E - x.exp;
        rs       = '0;
        mask     = '0;
        if (x.exp < BIAS_E) begin
            // |value| < 1: everything is fraction
            if (down < EXP_W'(MANT_W)) frac_mag = mant >> down[SH_W-1:0];
        end else if (up >= EXP_W'(MANT_W)) begin
            int_mag = MANT_W'(INT_LIMIT);
            ovf_o   = 1'b1;
        end else begin
            rs       = SH_W'(FRAC_W) - up[SH_W-1:0];
            mask     = (MANT_W'(1) << rs) - MANT_W'(1);
            int_mag  = mant >> rs;
            frac_mag = (mant & mask) << up[SH_W-1:0];
            ovf_o    = int_mag == MANT_W'(INT_LIMIT);
        end
        int_o  = x.sign ? -DATA_W'(int_mag)  : DATA_W'(int_mag);
        frac_o = x.sign ? -DATA_W'(frac_mag) : DATA_W'(frac_mag);
    end
endmodule

// File: rtl/bffu_u2f.sv
module bffu_u2f
    import bffu_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    output logic [DATA_W-1:0] flt_o
);
    localparam logic [EXP_W-1:0] BIAS_E = EXP_W'(BIAS);
    localparam int LOW_W = DATA_W - MANT_W;

    logic [POS_W-1:0]  pos;
    logic [DATA_W-1:0] norm;
    logic [MANT_W-1:0] keep;
    logic              guard, sticky, bump;
    logic [MANT_W:0]   rounded;
    logic [EXP_W-1:0]  e;

    always_comb begin
        pos     = top_bit(a_i);
        norm    = align_top(a_i, pos);
        keep    = norm[DATA_W-1 -: MANT_W];
        guard   = norm[LOW_W-1];
        sticky  = |norm[LOW_W-2:0];
        bump    = guard & (sticky | keep[0]);
        rounded = {1'b0, keep} + (MANT_W+1)'(bump);
        e       = BIAS_E + EXP_W'(pos) + EXP_W'(rounded[MANT_W]);
        if (a_i == '0) begin
            flt_o = '0;
        end else if (rounded[MANT_W]) begin
            flt_o = {1'b0, e, {FRAC_W{1'b0}}};
        end else begin
            flt_o = {1'b0, e, rounded[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/bf16_field_unit.sv
module bf16_field_unit
    import bffu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o,
    output logic              pred_o
);
    logic [DATA_W-1:0] mant_w, addexp_w, subexp_w, exp2f_w;
    logic [DATA_W-1:0] int_w, frac_w, u2f_w;
    logic              ovf_w;
    logic [DATA_W-1:0] res_d;
    logic              pred_d;
    bffu_op_e          op;

    bffu_exp_ops u_exp (
        .a_i      (a_i),
        .b_i      (b_i),
        .mant_o   (mant_w),
        .addexp_o (addexp_w),
        .subexp_o (subexp_w),
        .exp2f_o  (exp2f_w)
    );

    bffu_int_split u_split (
        .a_i    (a_i),
        .int_o  (int_w),
        .frac_o (frac_w),
        .ovf_o  (ovf_w)
    );

    bffu_u2f u_cvt (
        .a_i   (a_i),
        .flt_o (u2f_w)
    );

    always_comb begin
        op     = bffu_op_e'(op_i);
        pred_d = 1'b0;
        unique case (op)
            OP_MANT:   res_d = mant_w;
            OP_ADDEXP: res_d = addexp_w;
            OP_SUBEXP: res_d = subexp_w;
            OP_EXP2F:  res_d = exp2f_w;
            OP_INT: begin
                res_d  = int_w;
                pred_d = ovf_w;
            end
            OP_FRAC:   res_d = frac_w;
            OP_U2F:    res_d = u2f_w;
            default:   res_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o  <= '0;
            pred_o <= 1'b0;
        end else begin
            res_o  <= res_d;
            pred_o <= pred_d;
        end
    end
endmodule

// File: rtl/bffu_checker.sv
module bffu_checker
    import bffu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic [DATA_W-1:0] res_o,
    input logic              pred_o
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (res_o == '0 && !pred_o));

    p_mant_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_MANT) |=> (res_o[DATA_W-1:FRAC_W] == '0 && res_o[FRAC_W-1:0] == $past(a_i[FRAC_W-1:0])));

    p_addexp_keeps_fields_r3: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ADDEXP) |=> (res_o[DATA_W-1] == $past(a_i[DATA_W-1]) && res_o[FRAC_W-1:0] == $past(a_i[FRAC_W-1:0])));

    p_subexp_sign_or_r4: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SUBEXP) |=> (res_o[DATA_W-1] == $past(a_i[DATA_W-1] | b_i[DATA_W-1])
                                 && res_o[FRAC_W-1:0] == $past(a_i[FRAC_W-1:0])));

    p_int_pred_saturation_r7: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_INT) |=> (pred_o == (res_o == 16'h00FF || res_o == 16'hFF01)));

    p_u2f_positive_r9: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_U2F) |=> !res_o[DATA_W-1]);

    p_pred_low_other_ops_r10: assert property (@(posedge clk) disable iff (rst)
        (op_i != OP_INT) |=> !pred_o);
endmodule

bind bf16_field_unit bffu_checker u_chk (.*);

// File: tb/test_bf16_field_unit.sv
module test_bf16_field_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op  = '0;
    logic [15:0] a   = '0;
    logic [15:0] b   = '0;
    logic [15:0] res;
    logic        pred;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bf16_field_unit i_bf16_field_unit (
        .clk(clk), .rst(rst), .op_i(op), .a_i(a), .b_i(b),
        .res_o(res), .pred_o(pred)
    );

    // {op, A, B, expected result, expected predicate}
    localparam int NV = 30;
    localparam logic [51:0] VEC [NV] = '{
        {3'd0, 16'h3FD5, 16'h1234, 16'h0055, 1'b0},
        {3'd0, 16'hFFFF, 16'h0000, 16'h007F, 1'b0},
        {3'd1, 16'h7F8A, 16'h0005, 16'h020A, 1'b0},
        {3'd1, 16'hC040, 16'hFFFE, 16'hBF40, 1'b0},
        {3'd2, 16'h7F8A, 16'h4005, 16'h7F0A, 1'b0},
        {3'd2, 16'h3F80, 16'hC000, 16'hBF00, 1'b0},
        {3'd2, 16'h0080, 16'h7F00, 16'h4100, 1'b0},
        {3'd3, 16'h4020, 16'h0000, 16'h3F80, 1'b0},
        {3'd3, 16'h3F80, 16'h0000, 16'h0000, 1'b0},
        {3'd3, 16'h0000, 16'h0000, 16'hC2FE, 1'b0},
        {3'd3, 16'h7F80, 16'h0000, 16'h4300, 1'b0},
        {3'd4, 16'h4020, 16'h0000, 16'h0002, 1'b0},
        {3'd4, 16'hC2F7, 16'h0000, 16'hFF85, 1'b0},
        {3'd4, 16'h437F, 16'h0000, 16'h00FF, 1'b1},
        {3'd4, 16'h3F00, 16'h0000, 16'h0000, 1'b0},
        {3'd4, 16'hC400, 16'h0000, 16'hFF01, 1'b1},
        {3'd4, 16'h437E, 16'h0000, 16'h00FE, 1'b0},
        {3'd5, 16'h4020, 16'h0000, 16'h0040, 1'b0},
        {3'd5, 16'hBFA0, 16'h0000, 16'hFFE0, 1'b0},
        {3'd5, 16'h3E80, 16'h0000, 16'h0020, 1'b0},
        {3'd5, 16'h4300, 16'h0000, 16'h0000, 1'b0},
        {3'd6, 16'h0000, 16'h0000, 16'h0000, 1'b0},
        {3'd6, 16'h0001, 16'h0000, 16'h3F80, 1'b0},
        {3'd6, 16'h00FF, 16'h0000, 16'h437F, 1'b0},
        {3'd6, 16'h0101, 16'h0000, 16'h4380, 1'b0},
        {3'd6, 16'h0103, 16'h0000, 16'h4382, 1'b0},
        {3'd6, 16'hFFFF, 16'h0000, 16'h4780, 1'b0},
        {3'd6, 16'h0181, 16'h0000, 16'h43C0, 1'b0},
        {3'd6, 16'h0203, 16'h0000, 16'h4401, 1'b0},
        {3'd7, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0}
    };

    function automatic string res_tag(input logic [2:0] o);
        case (o)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R8";
            3'd6: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive on a falling edge, sample on the next falling edge (one rising edge between).
    task automatic apply(input logic [2:0] o, input logic [15:0] x, input logic [15:0] y);
        @(negedge clk);
        op = o; a = x; b = y;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset result", res, 16'h0000);
        check("R1 reset pred", {15'b0, pred}, 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][51:49], VEC[i][48:33], VEC[i][32:17]);
            check(res_tag(VEC[i][51:49]), res, VEC[i][16:1]);
            check((VEC[i][51:49] == 3'd4) ? "R7 pred" : "R10 pred",
                  {15'b0, pred}, {15'b0, VEC[i][0]});
        end

        // R7 / R10: overflow predicate then another op on the next cycle
        apply(3'd4, 16'h4500, 16'h0000);
        check("R7 far overflow pred", {15'b0, pred}, 16'h0001);
        check("R6 far overflow sat", res, 16'h00FF);
        apply(3'd1, 16'h4500, 16'h0000);
        check("R10 pred drops after int", {15'b0, pred}, 16'h0000);
        check("R3 add zero keeps word", res, 16'h4500);

        // R1: output holds until the next edge
        @(negedge clk);
        op = 3'd0; a = 16'h0003;
        #2;
        check("R1 held before edge", res, 16'h4500);
        @(negedge clk);
        check("R1 updated after edge", res, 16'h0003);

        // R1: synchronous reset clears a live result
        apply(3'd4, 16'h437F, 16'h0000);
        check("R7 pred before reset", {15'b0, pred}, 16'h0001);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears result", res, 16'h0000);
        check("R1 reset clears pred", {15'b0, pred}, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        check("R6 after reset release", res, 16'h00FF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule